// File: doc/BRIEF.md
# Critical-Section Offload Queue

This block sits beside a large core and collects critical-section calls that small cores offload to it. Each call names a lock, the code address of the section, a stack pointer and the core that made the call. Calls wait in an 8-slot queue. A dispatcher takes one at a time and moves it through a fixed sequence: it takes the lock through a lock port, starts the section on an execution port, waits for completion, and gives the lock back. It then queues a done response addressed to the calling core. That core stays stalled until the response reaches it.

Every data-carrying edge is valid/ready. A transfer happens on a cycle where both are high. Once valid is raised, it and its payload stay fixed until ready is seen. The queue lowers `req_ready` only when full. Responses leave in completion order, one per cycle at most, and are held while `rsp_ready` is low. The lock port carries both acquire and release requests, with an op bit that tells them apart.

Top module: `cs_offload_queue`

## Requirements
- R1: A synchronous active-high reset empties the request queue and the response queue and clears the held-lock flag. After reset `req_ready`=1 and `lk_valid`, `ex_valid` and `rsp_valid` are all 0.
- R2: A call is stored on a cycle with `req_valid`=1 and `req_ready`=1. `req_ready` is 0 exactly when 8 calls are stored. A removal in the same cycle does not raise it.
- R3: When the dispatcher is idle and the queue is not empty, it removes the oldest stored call. From the next cycle it drives `lk_valid`=1, `lk_acquire`=1 and `lk_id` set to that call's lock. These stay until `lk_ready`=1.
- R4: The cycle that completes a release also picks the next call. It takes the oldest stored call whose lock differs from the lock being released, and that call's acquire starts on the next cycle. If every stored call names the released lock, the dispatcher goes idle for one cycle and then follows R3.
- R5: After the acquire completes, `ex_valid`=1 is driven with the call's `ex_pc` and `ex_sp` until `ex_ready`=1. The block then waits for `ex_done`=1. `ex_done` is ignored in every other phase.
- R6: After `ex_done`, a release is offered with `lk_valid`=1, `lk_acquire`=0 and the same `lk_id`. It is offered only while the response queue (4 slots) has a free slot.
- R7: When a release completes, a response {core, lock} enters the response queue. `rsp_valid`, `rsp_core` and `rsp_lock` show the oldest pending response. Responses leave in completion order, one per cycle at most, and stay unchanged while `rsp_ready`=0.
- R8: Only one call is in service. No acquire is offered between an acquire completing and the matching release completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Call request valid |
| req_ready | output | 1 | Queue can take a call |
| req_lock | input | 8 | Lock named by the call |
| req_pc | input | 16 | Code address of the section |
| req_sp | input | 16 | Caller stack pointer |
| req_core | input | 3 | Calling core number |
| lk_valid | output | 1 | Lock request valid |
| lk_ready | input | 1 | Lock storage accepts the request |
| lk_acquire | output | 1 | 1 = acquire, 0 = release |
| lk_id | output | 8 | Lock being acquired or released |
| ex_valid | output | 1 | Start request to the execution engine |
| ex_ready | input | 1 | Engine accepts the start |
| ex_pc | output | 16 | Section code address |
| ex_sp | output | 16 | Stack pointer for the section |
| ex_done | input | 1 | Engine finished the running section |
| rsp_valid | output | 1 | Done response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_core | output | 3 | Core the response is for |
| rsp_lock | output | 8 | Lock of the finished section |

## Verification
A wrong slot shift or a wrong write position in the request queue shows up as a wrong `lk_id`, `ex_pc` or `ex_sp` at the next dispatch. A lost or duplicated call shows up when the model's queue length disagrees with `req_ready` near full. A fault in the skip-the-released-lock pick shows up in the cycle right after a release, as an acquire for the wrong lock or an idle cycle where none is expected. Response ordering faults show up as a mismatched `rsp_core`/`rsp_lock` as soon as two responses are pending under back-pressure. Every output is compared against the model on every cycle, so each fault is reported in the first cycle it becomes visible.

// File: rtl/cs_pkg.sv
package cs_pkg;
  parameter int unsigned LOCK_W = 8;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned CORE_W = 3;

  typedef struct packed {
    logic [LOCK_W-1:0] lock;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] sp;
    logic [CORE_W-1:0] core;
  } cs_req_t;

  typedef struct packed {
    logic [CORE_W-1:0] core;
    logic [LOCK_W-1:0] lock;
  } cs_rsp_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQ, ST_START, ST_RUN, ST_REL
  } cs_state_e;
endpackage

// File: rtl/cs_req_store.sv
module cs_req_store
  import cs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  cs_req_t          push_req,
  input  logic             pop,
  input  logic [IDX_W-1:0] pop_idx,
  output cs_req_t          slots [DEPTH],
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [CNT_W-1:0] wpos;

  assign full = (count == CNT_W'(DEPTH));

  // new entry lands after the survivors of any removal this cycle
  always_comb begin
    wpos = pop ? (count - CNT_W'(1)) : count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (pop && (i >= int'(pop_idx))) slots[i] <= slots[i+1];
      end
      if (push) slots[wpos[IDX_W-1:0]] <= push_req;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> (CNT_W'(pop_idx) < count));
endmodule

// File: rtl/cs_pick.sv
module cs_pick
  import cs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  cs_req_t           slots [DEPTH],
  input  logic [CNT_W-1:0]  count,
  input  logic              excl_v,
  input  logic [LOCK_W-1:0] excl_lock,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  logic [DEPTH-1:0] elig;

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign elig[g] = (CNT_W'(g) < count) && !(excl_v && (slots[g].lock == excl_lock));
  end

  // lowest slot index is the oldest call
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cs_rsp_fifo.sv
module cs_rsp_fifo
  import cs_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  cs_rsp_t push_data,
  output logic    full,
  output logic    out_valid,
  input  logic    out_ready,
  output cs_rsp_t out_data
);
  cs_rsp_t          mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             do_pop, do_push;

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_pop    = out_valid && out_ready;
  assign do_push   = push && !full;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_rsp_room_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/cs_offload_queue.sv
module cs_offload_queue
  import cs_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned RSP_DEPTH  = 4,
  localparam int unsigned IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LOCK_W-1:0] req_lock,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_sp,
  input  logic [CORE_W-1:0] req_core,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic              lk_acquire,
  output logic [LOCK_W-1:0] lk_id,
  output logic              ex_valid,
  input  logic              ex_ready,
  output logic [ADDR_W-1:0] ex_pc,
  output logic [ADDR_W-1:0] ex_sp,
  input  logic              ex_done,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CORE_W-1:0] rsp_core,
  output logic [LOCK_W-1:0] rsp_lock
);
  cs_state_e        st;
  cs_req_t          cur;
  logic             held_v;
  cs_req_t          slots [DEPTH];
  logic [CNT_W-1:0] count;
  logic             full, found, pop, lk_fire, rsp_full;
  logic [IDX_W-1:0] pick_idx;
  cs_req_t          in_req;
  cs_rsp_t          rsp_out;

  assign in_req    = '{lock: req_lock, pc: req_pc, sp: req_sp, core: req_core};
  assign req_ready = !full;

  cs_req_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push(req_valid && req_ready), .push_req(in_req),
    .pop(pop), .pop_idx(pick_idx),
    .slots(slots), .count(count), .full(full)
  );

  cs_pick #(.DEPTH(DEPTH)) u_pick (
    .slots(slots), .count(count),
    .excl_v(held_v), .excl_lock(cur.lock),
    .found(found), .idx(pick_idx)
  );

  cs_rsp_fifo #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk(clk), .rst(rst),
    .push((st == ST_REL) && lk_fire),
    .push_data('{core: cur.core, lock: cur.lock}),
    .full(rsp_full),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_out)
  );

  assign rsp_core   = rsp_out.core;
  assign rsp_lock   = rsp_out.lock;
  assign lk_valid   = (st == ST_ACQ) || ((st == ST_REL) && !rsp_full);
  assign lk_acquire = (st == ST_ACQ);
  assign lk_id      = cur.lock;
  assign lk_fire    = lk_valid && lk_ready;
  assign ex_valid   = (st == ST_START);
  assign ex_pc      = cur.pc;
  assign ex_sp      = cur.sp;
  assign pop        = found && ((st == ST_IDLE) || ((st == ST_REL) && lk_fire));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cur    <= '0;
      held_v <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (found) begin
          cur <= slots[pick_idx];
          st  <= ST_ACQ;
        end
        ST_ACQ: if (lk_fire) begin
          held_v <= 1'b1;
          st     <= ST_START;
        end
        ST_START: if (ex_ready) st <= ST_RUN;
        ST_RUN:   if (ex_done)  st <= ST_REL;
        ST_REL: if (lk_fire) begin
          held_v <= 1'b0;
          if (found) begin
            cur <= slots[pick_idx];
            st  <= ST_ACQ;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_acq_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_acquire && !lk_ready) |=> (lk_valid && lk_acquire && $stable(lk_id)));
  p_ex_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_ready) |=> (ex_valid && $stable(ex_pc) && $stable(ex_sp)));
  p_single_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_acquire) |-> !held_v);
  p_rel_room_r6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_acquire) |-> !rsp_full);
  p_skip_held_r4: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_REL) && lk_fire && found) |=> (lk_valid && lk_acquire && (lk_id != $past(cur.lock))));
endmodule

// File: tb/cs_offload_queue_bench.sv
`timescale 1ns/1ps
module cs_offload_queue_bench;
  import cs_pkg::*;
  localparam int DEPTH = 8;
  localparam int RD    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, lk_ready = 0, ex_ready = 0, ex_done = 0, rsp_ready = 0;
  logic [LOCK_W-1:0] req_lock = '0;
  logic [ADDR_W-1:0] req_pc = '0, req_sp = '0;
  logic [CORE_W-1:0] req_core = '0;
  logic req_ready, lk_valid, lk_acquire, ex_valid, rsp_valid;
  logic [LOCK_W-1:0] lk_id, rsp_lock;
  logic [ADDR_W-1:0] ex_pc, ex_sp;
  logic [CORE_W-1:0] rsp_core;

  always #2 clk = ~clk;

  cs_offload_queue u_cs_offload_queue (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_lock(req_lock),
    .req_pc(req_pc), .req_sp(req_sp), .req_core(req_core),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_acquire(lk_acquire), .lk_id(lk_id),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_pc(ex_pc), .ex_sp(ex_sp),
    .ex_done(ex_done),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_core(rsp_core), .rsp_lock(rsp_lock)
  );

  // behavioural reference state
  cs_req_t mq[$];
  cs_rsp_t mr[$];
  cs_req_t mcur;
  int      mst;   // 0 idle, 1 acquire, 2 start, 3 run, 4 release
  int      vectors = 0, fails = 0;
  bit      done = 0;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mr.delete(); mst = 0; mcur = '0;
    end else begin
      bit acc, rfull, rpop;
      acc   = req_valid && (mq.size() < DEPTH);
      rfull = (mr.size() == RD);
      rpop  = (mr.size() > 0) && rsp_ready;
      if (rpop) void'(mr.pop_front());
      case (mst)
        0: if (mq.size() > 0) begin mcur = mq[0]; mq.delete(0); mst = 1; end
        1: if (lk_ready) mst = 2;
        2: if (ex_ready) mst = 3;
        3: if (ex_done)  mst = 4;
        4: if (!rfull && lk_ready) begin
          int k;
          cs_rsp_t r;
          r.core = mcur.core; r.lock = mcur.lock;
          mr.push_back(r);
          k = -1;
          for (int i = 0; i < mq.size(); i++)
            if (k < 0 && mq[i].lock != mcur.lock) k = i;
          if (k >= 0) begin mcur = mq[k]; mq.delete(k); mst = 1; end
          else mst = 0;
        end
        default: mst = 0;
      endcase
      if (acc) begin
        cs_req_t e;
        e.lock = req_lock; e.pc = req_pc; e.sp = req_sp; e.core = req_core;
        mq.push_back(e);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  task automatic compare(input bit after_rst);
    bit lv;
    lv = (mst == 1) || (mst == 4 && mr.size() < RD);
    if (after_rst) begin
      chk("R1 req_ready", 32'(req_ready), 1);
      chk("R1 lk_valid", 32'(lk_valid), 0);
      chk("R1 ex_valid", 32'(ex_valid), 0);
      chk("R1 rsp_valid", 32'(rsp_valid), 0);
      return;
    end
    chk("R2 req_ready", 32'(req_ready), 32'(mq.size() < DEPTH));
    chk("R3 R6 R8 lk_valid", 32'(lk_valid), 32'(lv));
    if (lv) begin
      chk("R8 lk_acquire", 32'(lk_acquire), 32'(mst == 1));
      chk("R4 lk_id", 32'(lk_id), 32'(mcur.lock));
    end
    chk("R5 ex_valid", 32'(ex_valid), 32'(mst == 2));
    if (mst == 2) begin
      chk("R5 ex_pc", 32'(ex_pc), 32'(mcur.pc));
      chk("R5 ex_sp", 32'(ex_sp), 32'(mcur.sp));
    end
    chk("R7 rsp_valid", 32'(rsp_valid), 32'(mr.size() > 0));
    if (mr.size() > 0) begin
      chk("R7 rsp_core", 32'(rsp_core), 32'(mr[0].core));
      chk("R7 rsp_lock", 32'(rsp_lock), 32'(mr[0].lock));
    end
  endtask

  initial begin
    bit prev_rst;
    prev_rst = 1;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      int pv, pr;
      @(negedge clk);
      if (cyc > 0) compare(prev_rst);
      prev_rst = rst;
      rst = (cyc < 3) || (cyc >= 4000 && cyc < 4002);
      if (cyc < 2000)      begin pv = 80; pr = 15; end
      else if (cyc < 4000) begin pv = 25; pr = 90; end
      else if (cyc < 6000) begin pv = 60; pr = 50; end
      else                 begin pv = 95; pr = 5;  end
      req_valid = ($urandom_range(0, 99) < pv);
      req_lock  = (cyc % 3 == 0) ? LOCK_W'($urandom) : LOCK_W'($urandom_range(0, 2));
      req_pc    = ADDR_W'($urandom);
      req_sp    = ADDR_W'($urandom);
      req_core  = CORE_W'($urandom);
      lk_ready  = ($urandom_range(0, 99) < 60);
      ex_ready  = ($urandom_range(0, 99) < 60);
      ex_done   = ($urandom_range(0, 99) < 35);
      rsp_ready = ($urandom_range(0, 99) < pr);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule